// File: doc/BRIEF.md
# Linked-List DMA Descriptor Sequencer

This block sequences one DMA channel through a chain of descriptors held in memory. Software writes the first descriptor into the channel registers: the link word, the byte count, the source and destination addresses and the configuration word. Writing the configuration word with its enable bit set while the channel is idle starts the channel. The sequencer then requests a transfer from an external datapath. The datapath reports progress one 32-bit beat (four bytes) at a time, and the sequencer counts the remaining bytes down.

When the count of the current descriptor reaches zero, the sequencer looks at the link word. If the link is nonzero and its chain flag is set, the sequencer reads the eight words of the next 32-byte descriptor through a simple word-read memory port. It loads them into the channel registers and carries on. If the link does not continue, the channel drops busy, clears its own enable bit and pulses a completion output once.

Clearing the enable bit while the channel is busy pauses the datapath request, and setting it again resumes it. The remaining count and the live link word can be read back at any time. Burst generation and the data movement itself belong to the datapath.

Top module: `lldma_seq`

## Requirements
- R1: After reset, busy, xferReq, memReq and doneIrq are low, and every channel register reads back zero.
- R2: The channel registers sit at byte offsets 0x00 (link), 0x10 (count), 0x14 (source), 0x18 (destination) and 0x1C (config). They read back what was written, except for the count. The count keeps only bits [12:2] of the written word, so that it is a multiple of 4 no larger than 0x1FFC. It reads back zero-extended.
- R3: A write to config with bit 0 set while idle starts the channel. busy is high from the next cycle. xferReq is high while the channel is enabled and the count is nonzero. xferSrc and xferDst present the source and destination registers.
- R4: Each cycle with beatDone and xferReq both high lowers the count by 4. A beatDone while xferReq is low leaves the count unchanged.
- R5: Clearing config bit 0 while busy drops xferReq but keeps busy high. Setting bit 0 again restores xferReq.
- R6: When the count reaches zero and the link word is nonzero with bit 1 set, the sequencer reads eight words in ascending order from (link with bits [4:0] cleared) + 4k, for k = 0 to 7. It holds memReq and memAddr until memRdValid. Words 0, 4, 5, 6 and 7 load the link, count, source, destination and config. Words 1 to 3 are discarded. Running then continues with the new descriptor.
- R7: When the count reaches zero and the link is zero or its bit 1 is clear, the sequencer fetches nothing. doneIrq is high for exactly one cycle, busy falls in that same cycle, and config bit 0 reads back as zero.
- R8: While busy, writes to the link, count, source and destination registers are ignored. Writes to config are accepted.
- R9: Config fields are decoded onto the outputs: xferDir = config[3:2] (01 memory to peripheral, 10 peripheral to memory), xferLine = config[11:4], xferSrcInc = config[31] and xferDstInc = config[30]. xferCfg carries the whole word.
- R10: A descriptor with a zero count completes without xferReq ever being raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrAddr | input | 6 | Register write byte offset |
| regWrData | input | 32 | Register write data |
| regRdAddr | input | 6 | Register read byte offset |
| regRdData | output | 32 | Register read data (combinational) |
| memReq | output | 1 | Descriptor word read request |
| memAddr | output | 32 | Descriptor word byte address |
| memRdValid | input | 1 | Read data valid, ends the current request |
| memRdData | input | 32 | Read data |
| xferReq | output | 1 | Transfer request to the datapath |
| beatDone | input | 1 | Datapath moved one 4-byte beat |
| xferSrc | output | 32 | Current source address |
| xferDst | output | 32 | Current destination address |
| xferCfg | output | 32 | Current config word |
| xferDir | output | 2 | Transfer direction field |
| xferLine | output | 8 | Peripheral request line |
| xferSrcInc | output | 1 | Source increment flag |
| xferDstInc | output | 1 | Destination increment flag |
| busy | output | 1 | Channel active |
| doneIrq | output | 1 | One-cycle chain-complete pulse |

## Verification
The assertions assume that the memory answers each request with memRdValid high for a single cycle while memReq is high, and never returns data without a request. The bench's memory model raises memRdValid one cycle after it sees memReq and lowers it the cycle after that, so each request is answered exactly once. The assertions also assume that beatDone matters only while xferReq is high. The bench drives beatDone either straight from xferReq or as isolated manual pulses, which it uses on purpose to probe the ignored case. Descriptors placed in the bench memory are 32-byte aligned, and the low link bits are used only to exercise the masking.

// File: rtl/lldma_seq_pkg.sv
package lldma_seq_pkg;

  localparam int REG_AW     = 6;
  localparam int DESC_WORDS = 8;
  localparam int IDX_W      = $clog2(DESC_WORDS);
  localparam int ALIGN_BITS = $clog2(DESC_WORDS * 4);

  // channel register byte offsets
  localparam logic [REG_AW-1:0] OFF_LINK  = 6'h00;
  localparam logic [REG_AW-1:0] OFF_COUNT = 6'h10;
  localparam logic [REG_AW-1:0] OFF_SRC   = 6'h14;
  localparam logic [REG_AW-1:0] OFF_DST   = 6'h18;
  localparam logic [REG_AW-1:0] OFF_CFG   = 6'h1C;

  // descriptor word slots
  localparam logic [IDX_W-1:0] SLOT_LINK  = 3'd0;
  localparam logic [IDX_W-1:0] SLOT_COUNT = 3'd4;
  localparam logic [IDX_W-1:0] SLOT_SRC   = 3'd5;
  localparam logic [IDX_W-1:0] SLOT_DST   = 3'd6;
  localparam logic [IDX_W-1:0] SLOT_CFG   = 3'd7;

  // config and link bit positions
  localparam int CFG_EN_BIT    = 0;
  localparam int LINK_CHAIN_BIT = 1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FETCH = 2'd2
  } seqState_t;

  typedef struct packed {
    logic             startFetch;
    logic             loadWord;
    logic [IDX_W-1:0] wordIdx;
    logic             decCount;
    logic             clrEnable;
  } seqCmd_t;

endpackage

// File: rtl/lldma_seq_ctrl.sv
module lldma_seq_ctrl
  import lldma_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  logic    enable,
  input  logic    countZero,
  input  logic    chainGo,
  input  logic    memRdValid,
  input  logic    beatDone,
  output seqCmd_t cmd,
  output logic    busy,
  output logic    xferReq,
  output logic    memReq,
  output logic    doneIrq
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

  seqState_t state, nextState;
  logic [IDX_W-1:0] wordIdx;
  logic chainEnd;

  assign busy    = (state != ST_IDLE);
  assign memReq  = (state == ST_FETCH);
  assign xferReq = (state == ST_RUN) && enable && !countZero;
  assign chainEnd = (state == ST_RUN) && countZero && !chainGo;

  always_comb begin
    nextState   = state;
    cmd         = '0;
    cmd.wordIdx = wordIdx;
    unique case (state)
      ST_IDLE: begin
        if (startReq) nextState = ST_RUN;
      end
      ST_RUN: begin
        if (countZero) begin
          if (chainGo) begin
            cmd.startFetch = 1'b1;
            nextState      = ST_FETCH;
          end else begin
            cmd.clrEnable = 1'b1;
            nextState     = ST_IDLE;
          end
        end else if (beatDone && enable) begin
          cmd.decCount = 1'b1;
        end
      end
      ST_FETCH: begin
        if (memRdValid) begin
          cmd.loadWord = 1'b1;
          if (wordIdx == LAST_IDX) nextState = ST_RUN;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      wordIdx <= '0;
      doneIrq <= 1'b0;
    end else begin
      state   <= nextState;
      doneIrq <= chainEnd;
      if (cmd.startFetch)    wordIdx <= '0;
      else if (cmd.loadWord) wordIdx <= wordIdx + 1'b1;
    end
  end

endmodule

// File: rtl/lldma_seq_regs.sv
module lldma_seq_regs
  import lldma_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCmd_t           cmd,
  input  logic              busy,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regWrAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [REG_AW-1:0] regRdAddr,
  output logic [DATA_W-1:0] regRdData,
  input  logic [DATA_W-1:0] memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              startReq,
  output logic              enable,
  output logic              countZero,
  output logic              chainGo,
  output logic [ADDR_W-1:0] xferSrc,
  output logic [ADDR_W-1:0] xferDst,
  output logic [DATA_W-1:0] xferCfg
);

  localparam int BASE_W = ADDR_W - ALIGN_BITS;

  logic [ADDR_W-1:0] linkReg;
  logic [CNT_W-1:0]  countReg;
  logic [ADDR_W-1:0] srcReg;
  logic [ADDR_W-1:0] dstReg;
  logic [DATA_W-1:0] cfgReg;
  logic [BASE_W-1:0] fetchBase;

  function automatic logic [CNT_W-1:0] alignCount(input logic [DATA_W-1:0] w);
    return {w[CNT_W-1:2], 2'b00};
  endfunction

  logic hostWr;
  assign hostWr = regWrEn && !busy;

  assign startReq  = regWrEn && (regWrAddr == OFF_CFG) && regWrData[CFG_EN_BIT] && !busy;
  assign enable    = cfgReg[CFG_EN_BIT];
  assign countZero = (countReg == '0);
  assign chainGo   = (linkReg != '0) && linkReg[LINK_CHAIN_BIT];
  assign memAddr   = {fetchBase, {(ALIGN_BITS-IDX_W-2){1'b0}}, cmd.wordIdx, 2'b00};
  assign xferSrc   = srcReg;
  assign xferDst   = dstReg;
  assign xferCfg   = cfgReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linkReg   <= '0;
      countReg  <= '0;
      srcReg    <= '0;
      dstReg    <= '0;
      cfgReg    <= '0;
      fetchBase <= '0;
    end else begin
      if (hostWr && regWrAddr == OFF_LINK)  linkReg  <= regWrData[ADDR_W-1:0];
      if (hostWr && regWrAddr == OFF_COUNT) countReg <= alignCount(regWrData);
      if (hostWr && regWrAddr == OFF_SRC)   srcReg   <= regWrData[ADDR_W-1:0];
      if (hostWr && regWrAddr == OFF_DST)   dstReg   <= regWrData[ADDR_W-1:0];
      if (regWrEn && regWrAddr == OFF_CFG)  cfgReg   <= regWrData;

      if (cmd.decCount)   countReg <= countReg - CNT_W'(4);
      if (cmd.clrEnable)  cfgReg[CFG_EN_BIT] <= 1'b0;
      if (cmd.startFetch) fetchBase <= linkReg[ADDR_W-1:ALIGN_BITS];

      if (cmd.loadWord) begin
        case (cmd.wordIdx)
          SLOT_LINK:  linkReg  <= memRdData[ADDR_W-1:0];
          SLOT_COUNT: countReg <= alignCount(memRdData);
          SLOT_SRC:   srcReg   <= memRdData[ADDR_W-1:0];
          SLOT_DST:   dstReg   <= memRdData[ADDR_W-1:0];
          SLOT_CFG:   cfgReg   <= memRdData;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    regRdData = '0;
    case (regRdAddr)
      OFF_LINK:  regRdData = DATA_W'(linkReg);
      OFF_COUNT: regRdData = DATA_W'(countReg);
      OFF_SRC:   regRdData = DATA_W'(srcReg);
      OFF_DST:   regRdData = DATA_W'(dstReg);
      OFF_CFG:   regRdData = cfgReg;
      default:   regRdData = '0;
    endcase
  end

endmodule

// File: rtl/lldma_seq.sv
module lldma_seq
  import lldma_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regWrAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [REG_AW-1:0] regRdAddr,
  output logic [DATA_W-1:0] regRdData,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memRdValid,
  input  logic [DATA_W-1:0] memRdData,
  output logic              xferReq,
  input  logic              beatDone,
  output logic [ADDR_W-1:0] xferSrc,
  output logic [ADDR_W-1:0] xferDst,
  output logic [DATA_W-1:0] xferCfg,
  output logic [1:0]        xferDir,
  output logic [7:0]        xferLine,
  output logic              xferSrcInc,
  output logic              xferDstInc,
  output logic              busy,
  output logic              doneIrq
);

  seqCmd_t cmd;
  logic startReq, enable, countZero, chainGo;

  lldma_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .enable     (enable),
    .countZero  (countZero),
    .chainGo    (chainGo),
    .memRdValid (memRdValid),
    .beatDone   (beatDone),
    .cmd        (cmd),
    .busy       (busy),
    .xferReq    (xferReq),
    .memReq     (memReq),
    .doneIrq    (doneIrq)
  );

  lldma_seq_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_regs (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (cmd),
    .busy       (busy),
    .regWrEn    (regWrEn),
    .regWrAddr  (regWrAddr),
    .regWrData  (regWrData),
    .regRdAddr  (regRdAddr),
    .regRdData  (regRdData),
    .memRdData  (memRdData),
    .memAddr    (memAddr),
    .startReq   (startReq),
    .enable     (enable),
    .countZero  (countZero),
    .chainGo    (chainGo),
    .xferSrc    (xferSrc),
    .xferDst    (xferDst),
    .xferCfg    (xferCfg)
  );

  // R9 field decode
  assign xferDir    = xferCfg[3:2];
  assign xferLine   = xferCfg[11:4];
  assign xferSrcInc = xferCfg[31];
  assign xferDstInc = xferCfg[30];

endmodule

// File: rtl/lldma_seq_chk.sv
module lldma_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              xferReq,
  input logic              memReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memRdValid,
  input logic              doneIrq
);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |=> !doneIrq);

  // R7
  done_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |-> (!busy && $past(busy)));

  // R3
  req_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferReq |-> busy);

  // R6
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memRdValid) |=> (memReq && $stable(memAddr)));

  // R6
  fetch_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (!xferReq && busy && memAddr[1:0] == 2'b00));

endmodule

bind lldma_seq lldma_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busy       (busy),
  .xferReq    (xferReq),
  .memReq     (memReq),
  .memAddr    (memAddr),
  .memRdValid (memRdValid),
  .doneIrq    (doneIrq)
);

// File: tb/lldma_seq_bench.sv
module lldma_seq_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [5:0]  regWrAddr = '0;
  logic [31:0] regWrData = '0;
  logic [5:0]  regRdAddr = '0;
  logic [31:0] regRdData;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memRdValid = 1'b0;
  logic [31:0] memRdData = '0;
  logic        xferReq;
  logic        beatDone;
  logic [31:0] xferSrc, xferDst, xferCfg;
  logic [1:0]  xferDir;
  logic [7:0]  xferLine;
  logic        xferSrcInc, xferDstInc;
  logic        busy, doneIrq;

  logic        autoMode = 1'b0;
  logic        manBeat = 1'b0;
  assign beatDone = autoMode ? xferReq : manBeat;

  int checks = 0;
  int fails = 0;
  int beatCnt = 0;
  int fetchCnt = 0;
  logic sawReq = 1'b0;
  logic [31:0] fetchLog [0:31];
  logic [31:0] mem [0:63];
  int cycles = 0;

  always #10 clk = ~clk;

  lldma_seq u_lldma_seq (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .regRdAddr(regRdAddr), .regRdData(regRdData),
    .memReq(memReq), .memAddr(memAddr), .memRdValid(memRdValid),
    .memRdData(memRdData), .xferReq(xferReq), .beatDone(beatDone),
    .xferSrc(xferSrc), .xferDst(xferDst), .xferCfg(xferCfg),
    .xferDir(xferDir), .xferLine(xferLine), .xferSrcInc(xferSrcInc),
    .xferDstInc(xferDstInc), .busy(busy), .doneIrq(doneIrq)
  );

  // memory model: one answer per request, one cycle after it is seen
  always @(posedge clk) begin
    if (memReq && !memRdValid) begin
      memRdValid <= 1'b1;
      memRdData  <= mem[memAddr[7:2]];
      if (fetchCnt < 32) fetchLog[fetchCnt] <= memAddr;
      fetchCnt <= fetchCnt + 1;
    end else begin
      memRdValid <= 1'b0;
    end
    if (beatDone && xferReq) beatCnt <= beatCnt + 1;
    if (xferReq) sawReq <= 1'b1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regWrAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [5:0] a, output logic [31:0] d);
    regRdAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic pulseBeat();
    @(negedge clk); manBeat = 1'b1;
    @(negedge clk); manBeat = 1'b0;
  endtask

  task automatic waitDone(input string req);
    int n = 0;
    while (!doneIrq && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check(req, {31'd0, doneIrq}, 32'd1);
    check(req, {31'd0, busy}, 32'd0);
    @(negedge clk);
    check(req, {31'd0, doneIrq}, 32'd0);
  endtask

  task automatic testReset();
    logic [31:0] v;
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 xferReq", {31'd0, xferReq}, 32'd0);
    check("R1 memReq", {31'd0, memReq}, 32'd0);
    check("R1 doneIrq", {31'd0, doneIrq}, 32'd0);
    for (int i = 0; i < 5; i++) begin
      logic [5:0] a;
      a = (i == 0) ? 6'h00 : 6'h10 + 6'(4 * (i - 1));
      rdReg(a, v);
      check("R1 regs", v, 32'd0);
    end
  endtask

  task automatic testRegs();
    logic [31:0] v;
    wrReg(6'h00, 32'h0000_0040); rdReg(6'h00, v); check("R2 link", v, 32'h40);
    wrReg(6'h14, 32'hA5A5_0004); rdReg(6'h14, v); check("R2 src", v, 32'hA5A5_0004);
    wrReg(6'h18, 32'h5A5A_0008); rdReg(6'h18, v); check("R2 dst", v, 32'h5A5A_0008);
    wrReg(6'h10, 32'h0000_1FFF); rdReg(6'h10, v); check("R2 count mask", v, 32'h1FFC);
    wrReg(6'h10, 32'hFFFF_FFFF); rdReg(6'h10, v); check("R2 count max", v, 32'h1FFC);
    wrReg(6'h1C, 32'h0000_3450); rdReg(6'h1C, v); check("R2 cfg", v, 32'h3450);
    check("R2 idle", {31'd0, busy}, 32'd0);
  endtask

  task automatic testSingle();
    logic [31:0] v;
    autoMode = 1'b0;
    wrReg(6'h00, 32'h0);
    wrReg(6'h10, 32'd12);
    wrReg(6'h14, 32'h0000_1100);
    wrReg(6'h18, 32'h0000_2200);
    wrReg(6'h1C, 32'h8000_0055);
    check("R3 busy", {31'd0, busy}, 32'd1);
    check("R3 xferReq", {31'd0, xferReq}, 32'd1);
    check("R3 src", xferSrc, 32'h1100);
    check("R3 dst", xferDst, 32'h2200);
    check("R9 dir", {30'd0, xferDir}, 32'd1);
    check("R9 line", {24'd0, xferLine}, 32'd5);
    check("R9 srcInc", {31'd0, xferSrcInc}, 32'd1);
    check("R9 dstInc", {31'd0, xferDstInc}, 32'd0);
    pulseBeat();
    rdReg(6'h10, v); check("R4 dec", v, 32'd8);
    wrReg(6'h1C, 32'h8000_0054);
    check("R5 paused req", {31'd0, xferReq}, 32'd0);
    check("R5 paused busy", {31'd0, busy}, 32'd1);
    pulseBeat();
    rdReg(6'h10, v); check("R4 ignored beat", v, 32'd8);
    wrReg(6'h1C, 32'h8000_0055);
    check("R5 resumed", {31'd0, xferReq}, 32'd1);
    pulseBeat();
    pulseBeat();
    waitDone("R7 single");
    rdReg(6'h1C, v); check("R7 en cleared", v, 32'h8000_0054);
  endtask

  task automatic testChain();
    logic [31:0] v;
    int b0, f0;
    for (int i = 0; i < 64; i++) mem[i] = 32'hDEAD_0000 | 32'(i);
    mem[16] = 32'h0000_0082; mem[20] = 32'd4;
    mem[21] = 32'h0000_1000; mem[22] = 32'h0000_2000; mem[23] = 32'h4000_0009;
    mem[32] = 32'h0;         mem[36] = 32'd8;
    mem[37] = 32'h0000_3000; mem[38] = 32'h0000_4000; mem[39] = 32'h8000_0005;
    b0 = beatCnt; f0 = fetchCnt;
    wrReg(6'h00, 32'h0000_004B);
    wrReg(6'h10, 32'd8);
    wrReg(6'h14, 32'h10);
    wrReg(6'h18, 32'h20);
    autoMode = 1'b1;
    wrReg(6'h1C, 32'h1);
    waitDone("R6 chain done");
    autoMode = 1'b0;
    check("R6 fetch count", 32'(fetchCnt - f0), 32'd16);
    for (int k = 0; k < 8; k++) begin
      check("R6 addr A", fetchLog[f0 + k], 32'h40 + 32'(4 * k));
      check("R6 addr B", fetchLog[f0 + 8 + k], 32'h80 + 32'(4 * k));
    end
    check("R4 beats", 32'(beatCnt - b0), 32'd5);
    rdReg(6'h00, v); check("R6 link live", v, 32'h0);
    rdReg(6'h14, v); check("R6 src", v, 32'h3000);
    rdReg(6'h18, v); check("R6 dst", v, 32'h4000);
    rdReg(6'h1C, v); check("R7 cfg", v, 32'h8000_0004);
  endtask

  task automatic testNoChain();
    int b0, f0;
    b0 = beatCnt; f0 = fetchCnt;
    wrReg(6'h00, 32'h0000_0041);
    wrReg(6'h10, 32'd4);
    autoMode = 1'b1;
    wrReg(6'h1C, 32'h1);
    waitDone("R7 flag clear");
    autoMode = 1'b0;
    check("R7 no fetch", 32'(fetchCnt - f0), 32'd0);
    check("R7 beats", 32'(beatCnt - b0), 32'd1);
  endtask

  task automatic testBusyWrites();
    logic [31:0] v;
    wrReg(6'h00, 32'h0);
    wrReg(6'h10, 32'd8);
    wrReg(6'h14, 32'h111);
    wrReg(6'h18, 32'h333);
    wrReg(6'h1C, 32'h1);
    wrReg(6'h10, 32'h100);
    wrReg(6'h14, 32'h222);
    wrReg(6'h18, 32'h444);
    wrReg(6'h00, 32'h82);
    rdReg(6'h10, v); check("R8 count", v, 32'd8);
    rdReg(6'h14, v); check("R8 src", v, 32'h111);
    rdReg(6'h18, v); check("R8 dst", v, 32'h333);
    rdReg(6'h00, v); check("R8 link", v, 32'h0);
    wrReg(6'h1C, 32'h0000_0C31);
    rdReg(6'h1C, v); check("R8 cfg accepted", v, 32'h0C31);
    pulseBeat();
    pulseBeat();
    waitDone("R8 finish");
  endtask

  task automatic testZero();
    int b0;
    b0 = beatCnt;
    wrReg(6'h00, 32'h0);
    wrReg(6'h10, 32'd0);
    @(negedge clk); sawReq = 1'b0;
    autoMode = 1'b1;
    wrReg(6'h1C, 32'h1);
    waitDone("R10 zero done");
    autoMode = 1'b0;
    check("R10 no request", {31'd0, sawReq}, 32'd0);
    check("R10 no beats", 32'(beatCnt - b0), 32'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRegs();
    testSingle();
    testChain();
    testNoChain();
    testBusyWrites();
    testZero();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule